// File: doc/BRIEF.md
# Card Fault Handler with Interrupt Polling

This block sits in the readout controller of a branch of front-end cards. All cards share one interrupt line. While that line is high, the handler reads the error/status register of each card in turn through a request/done port to a serial bus master, which is outside this block. It skips cards it has already powered off. For each card that reports a fault, it sorts the fault into one of two classes and applies the policy for that class.

A hard fault covers these causes: current over threshold, a supply fault on the analog front end or the digitiser, or a fault on a regulator. The handler powers the card off at once. A soft fault covers these causes: temperature over threshold, voltage under threshold, or a missing sampling clock. The handler drops the card from the readout list. It then writes the faulting bits into the card's mask register and sends a clear-status command to the card. Each handled fault leaves one warning record in a FIFO that the supervisory system drains. When a pass over the branch ends with the interrupt still high, the handler starts a new pass at card 0.

Top module: `card_fault_handler`

## Requirements
- R1: During and after a synchronous reset, `card_off` is all zeros, `readout_en` is all ones, and `req_valid` and `wrn_valid` are low.
- R2: When `irq_in` is high and the handler is idle, it issues status reads (`req_write`=0, `req_reg`=0) one at a time, in ascending card address. Each request keeps `req_valid`, `req_write`, `req_card` and `req_reg` steady until the cycle in which `req_done` is high.
- R3: A card whose `card_off` bit is set is never addressed again, in this pass or in any later pass.
- R4: Status bits 4..0 are hard causes. If a read returns any of them, the card's `card_off` bit is set on the edge where `req_done` is sampled. In that case `readout_en` is not changed and no mask write is sent, even if soft bits are also set.
- R5: Status bits 7..5 are soft causes. If a read returns only soft bits, the card's `readout_en` bit is cleared on the done edge. The next two requests go to the same card: first a write to register 1 with `req_wdata` equal to the status read, then a write to register 2 (clear status).
- R6: A status read of zero changes no output and pushes no record.
- R7: Each handled fault pushes the record {hard flag, 4-bit card address, 8-bit status} onto `wrn_data`, with the hard flag in the top bit. The record is visible after the done edge. Records come out in handling order and the FIFO is first-word-fall-through. `wrn_pop` while `wrn_valid` is low is ignored.
- R8: While the warning FIFO is full, no new status read starts.
- R9: At the end of a pass, the handler starts again at card 0 if `irq_in` is high, and goes idle otherwise.
- R10: A `card_off` bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | Shared card interrupt, level |
| req_valid | output | 1 | Bus-master request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_card | output | 4 | Target card address |
| req_reg | output | 2 | 0 status, 1 mask, 2 clear |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | Request finished (one cycle) |
| req_rdata | input | 8 | Read data, valid with `req_done` |
| card_off | output | 13 | Per-card power-off |
| readout_en | output | 13 | Per-card readout list membership |
| wrn_valid | output | 1 | Warning record available |
| wrn_data | output | 13 | Warning record {hard, card, status} |
| wrn_pop | input | 1 | Remove head record |

## Verification
Every effect of a completed read is due one edge after `req_done` is sampled. This covers the power-off bit, the readout bit, the warning record and a follow-up mask write. The bench's reference model applies these effects at the same negative edge at which it drives `req_done`, so the comparison at the next negative edge lands on the updated outputs. The bus model answers after a latency from zero to three cycles, which covers back-to-back requests. It checks each new request, on the first negative edge where it is visible, against the expected card order and the soft-fault write sequence. Pops are driven at a negative edge and take effect at the next edge, so the FIFO head is compared with the model once per cycle.

// File: rtl/cfh_pkg.sv
package cfh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_READ,
    ST_MASK,
    ST_CLEAR
  } cfh_state_t;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_MASK   = 2'd1;
  localparam logic [1:0] REG_CLEAR  = 2'd2;
endpackage

// File: rtl/cfh_classify.sv
module cfh_classify #(
  parameter int ERR_W = 8,
  parameter logic [ERR_W-1:0] HARD_MASK = 8'h1F
) (
  input  logic [ERR_W-1:0] status,
  output logic             is_hard,
  output logic             is_soft
);
  always_comb begin
    is_hard = |(status & HARD_MASK);
    is_soft = !is_hard && |(status & ~HARD_MASK);
  end
endmodule

// File: rtl/cfh_warn_fifo.sv
module cfh_warn_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;
  logic          do_push, do_pop;

  assign do_push = push && (fill != DEPTH[AW:0]);
  assign do_pop  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
    end
  end

  assign dout  = mem[rd_ptr];
  assign valid = (fill != '0);
  assign full  = (fill == DEPTH[AW:0]);
endmodule

// File: rtl/card_fault_handler.sv
module card_fault_handler #(
  parameter int N_CARDS    = 13,
  parameter int ERR_W      = 8,
  parameter logic [ERR_W-1:0] HARD_MASK = 8'h1F,
  parameter int FIFO_DEPTH = 8,
  localparam int CARD_W    = $clog2(N_CARDS + 1),
  localparam int WRN_W     = 1 + CARD_W + ERR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_in,
  output logic               req_valid,
  output logic               req_write,
  output logic [CARD_W-1:0]  req_card,
  output logic [1:0]         req_reg,
  output logic [ERR_W-1:0]   req_wdata,
  input  logic               req_done,
  input  logic [ERR_W-1:0]   req_rdata,
  output logic [N_CARDS-1:0] card_off,
  output logic [N_CARDS-1:0] readout_en,
  output logic               wrn_valid,
  output logic [WRN_W-1:0]   wrn_data,
  input  logic               wrn_pop
);
  import cfh_pkg::*;

  localparam logic [CARD_W-1:0] LAST_IDX = CARD_W'(N_CARDS);

  cfh_state_t        state;
  logic [CARD_W-1:0] idx;
  logic              is_hard, is_soft;
  logic              fifo_full, wrn_push;
  logic [WRN_W-1:0]  wrn_din;

  cfh_classify #(.ERR_W(ERR_W), .HARD_MASK(HARD_MASK)) u_classify (
    .status (req_rdata),
    .is_hard(is_hard),
    .is_soft(is_soft)
  );

  assign wrn_push = (state == ST_READ) && req_done && (is_hard || is_soft);
  assign wrn_din  = {is_hard, idx, req_rdata};

  cfh_warn_fifo #(.W(WRN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (wrn_push),
    .din  (wrn_din),
    .pop  (wrn_pop),
    .dout (wrn_data),
    .valid(wrn_valid),
    .full (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_card   <= '0;
      req_reg    <= REG_STATUS;
      req_wdata  <= '0;
      card_off   <= '0;
      readout_en <= '1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (irq_in) begin
            idx   <= '0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx == LAST_IDX) begin
            if (irq_in) idx <= '0;
            else        state <= ST_IDLE;
          end else if (card_off[idx]) begin
            idx <= idx + 1'b1;
          end else if (!fifo_full) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_card  <= idx;
            req_reg   <= REG_STATUS;
            req_wdata <= '0;
            state     <= ST_READ;
          end
        end
        ST_READ: begin
          if (req_done) begin
            if (is_hard) begin
              card_off[idx] <= 1'b1;
              req_valid     <= 1'b0;
              idx           <= idx + 1'b1;
              state         <= ST_SCAN;
            end else if (is_soft) begin
              readout_en[idx] <= 1'b0;
              req_write       <= 1'b1;
              req_reg         <= REG_MASK;
              req_wdata       <= req_rdata;
              state           <= ST_MASK;
            end else begin
              req_valid <= 1'b0;
              idx       <= idx + 1'b1;
              state     <= ST_SCAN;
            end
          end
        end
        ST_MASK: begin
          if (req_done) begin
            req_reg   <= REG_CLEAR;
            req_wdata <= '0;
            state     <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          if (req_done) begin
            req_valid <= 1'b0;
            idx       <= idx + 1'b1;
            state     <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfh_checker.sv
module cfh_checker #(
  parameter int N_CARDS = 13,
  parameter int CARD_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [CARD_W-1:0]  req_card,
  input logic [1:0]         req_reg,
  input logic               req_done,
  input logic [N_CARDS-1:0] card_off,
  input logic [N_CARDS-1:0] readout_en,
  input logic               fifo_full
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_done) |=> (req_valid && $stable(req_write) &&
                                  $stable(req_card) && $stable(req_reg))); // R2

  AST_NO_READ_OF_OFF_CARD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (int'(req_card) < N_CARDS)) |-> !card_off[req_card]); // R3

  AST_HARD_KEEPS_READOUT: assert property (@(posedge clk) disable iff (rst)
    ((~readout_en & $past(readout_en) & card_off & ~$past(card_off)) == '0)); // R4

  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && !req_write) |-> !$past(fifo_full)); // R8

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((card_off & $past(card_off)) == $past(card_off))); // R10
endmodule

bind card_fault_handler cfh_checker #(.N_CARDS(N_CARDS), .CARD_W(CARD_W)) u_cfh_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_card  (req_card),
  .req_reg   (req_reg),
  .req_done  (req_done),
  .card_off  (card_off),
  .readout_en(readout_en),
  .fifo_full (fifo_full)
);

// File: tb/test_card_fault_handler.sv
`timescale 1ns/1ps
module test_card_fault_handler;
  localparam int N = 13, EW = 8, DEPTH = 8, CW = 4, WW = 1 + CW + EW;

  logic          clk = 1'b0, rst = 1'b1, irq = 1'b0;
  logic          req_done = 1'b0, wrn_pop = 1'b0;
  logic [EW-1:0] req_rdata = '0;
  logic          req_valid, req_write, wrn_valid;
  logic [CW-1:0] req_card;
  logic [1:0]    req_reg;
  logic [EW-1:0] req_wdata;
  logic [N-1:0]  card_off, readout_en;
  logic [WW-1:0] wrn_data;

  card_fault_handler i_card_fault_handler (
    .clk(clk), .rst(rst), .irq_in(irq),
    .req_valid(req_valid), .req_write(req_write), .req_card(req_card),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_done(req_done),
    .req_rdata(req_rdata), .card_off(card_off), .readout_en(readout_en),
    .wrn_valid(wrn_valid), .wrn_data(wrn_data), .wrn_pop(wrn_pop)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, idle_run = 0;
  logic [EW-1:0] err_of [N];
  logic [N-1:0]  m_off = '0, m_ro = '1;
  logic [WW-1:0] q [$];
  bit   busy = 0, pop_en = 1, pop_any = 0;
  int   cnt = 0, nreq = 0, exp_next = 0, mask_stage = 0, mask_card = 0;
  int   inject_at = -1, inject_card = 0;
  logic [EW-1:0] inject_err = '0, mask_err = '0;
  logic [CW-1:0] cur_card;
  logic          cur_wr;
  logic [1:0]    cur_reg;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_card(input int from);
    for (int i = from; i < N; i++) if (!m_off[i]) return i;
    for (int i = 0; i < N; i++) if (!m_off[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      // per-cycle comparison against the model
      chk(card_off === m_off, "R4 R10 card_off", 32'(card_off), 32'(m_off));
      chk(readout_en === m_ro, "R5 readout_en", 32'(readout_en), 32'(m_ro));
      chk(wrn_valid === (q.size() != 0), "R7 wrn_valid", 32'(wrn_valid), 32'(q.size() != 0));
      if (q.size() != 0) chk(wrn_data === q[0], "R7 wrn_data", 32'(wrn_data), 32'(q[0]));

      req_done = 1'b0;
      wrn_pop  = 1'b0;
      if (pop_en && wrn_valid) begin
        wrn_pop = 1'b1;
        void'(q.pop_front());
      end else if (pop_any) begin
        wrn_pop = 1'b1; // empty pop, must be ignored (R7)
      end

      if (!busy && req_valid) begin
        busy = 1; cnt = nreq % 4; nreq++;
        cur_card = req_card; cur_wr = req_write; cur_reg = req_reg;
        if (!req_write) begin
          chk(req_reg == 2'd0, "R2 status register", 32'(req_reg), 0);
          chk(next_card(exp_next) == int'(req_card), "R2 R3 R9 card order",
              32'(req_card), 32'(next_card(exp_next)));
          chk(mask_stage == 0, "R5 read before mask done", mask_stage, 0);
          chk(q.size() < DEPTH, "R8 read while FIFO full", q.size(), DEPTH - 1);
          exp_next = int'(req_card) + 1;
          if (inject_at == int'(req_card)) begin
            err_of[inject_card] = inject_err;
            inject_at = -1;
          end
        end else if (mask_stage == 1) begin
          chk(req_reg == 2'd1 && int'(req_card) == mask_card && req_wdata == mask_err,
              "R5 mask write", {22'd0, req_reg, req_card, req_wdata}, {22'd0, 2'd1, 4'(mask_card), mask_err});
          mask_stage = 2;
        end else if (mask_stage == 2) begin
          chk(req_reg == 2'd2 && int'(req_card) == mask_card, "R5 clear write",
              {26'd0, req_reg, req_card}, {26'd0, 2'd2, 4'(mask_card)});
          mask_stage = 3;
        end else begin
          chk(0, "R4 R6 unexpected write", 32'(req_card), 0);
        end
      end

      if (busy) begin
        if (cnt == 0) begin
          busy = 0;
          req_done = 1'b1;
          if (!cur_wr) begin
            logic [EW-1:0] e;
            e = err_of[cur_card];
            req_rdata = e;
            if (|(e & 8'h1F)) begin
              m_off[cur_card] = 1'b1;
              q.push_back({1'b1, cur_card, e});
            end else if (|(e & 8'hE0)) begin
              m_ro[cur_card] = 1'b0;
              q.push_back({1'b0, cur_card, e});
              mask_stage = 1; mask_card = int'(cur_card); mask_err = e;
            end
          end else if (mask_stage == 3) begin
            err_of[cur_card] = '0;
            mask_stage = 0;
          end
        end else begin
          cnt--;
        end
      end

      irq = 1'b0;
      for (int i = 0; i < N; i++) if (err_of[i] != 0 && !m_off[i]) irq = 1'b1;
      idle_run = (!irq && !req_valid && !busy) ? idle_run + 1 : 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic settle();
    @(posedge clk); #1;
    wait (idle_run >= 10);
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) err_of[i] = '0;
    repeat (3) @(negedge clk);
    chk(card_off == '0, "R1 card_off reset", 32'(card_off), 0);
    chk(readout_en == '1, "R1 readout_en reset", 32'(readout_en), 32'h1FFF);
    chk(!req_valid && !wrn_valid, "R1 req/wrn idle", {req_valid, wrn_valid}, 0);
    @(posedge clk); #1; rst = 1'b0;

    // R5: single soft fault on card 3
    @(posedge clk); #1; err_of[3] = 8'h20;
    settle();
    chk(readout_en[3] == 1'b0, "R5 card 3 removed", 32'(readout_en), 32'h1FF7);

    // R4: hard on card 7, hard+soft on card 9; R6 zero cards untouched
    err_of[7] = 8'h02; err_of[9] = 8'h41;
    settle();
    chk(card_off == 13'h0280, "R4 cards 7 and 9 off", 32'(card_off), 32'h0280);
    chk(readout_en == 13'h1FF7, "R4 R6 readout unchanged", 32'(readout_en), 32'h1FF7);

    // R9: fault on card 1 appears during the read of card 12 -> second pass
    inject_at = 12; inject_card = 1; inject_err = 8'h80; err_of[11] = 8'h40;
    settle();
    chk(readout_en[1] == 1'b0 && readout_en[11] == 1'b0, "R9 re-poll caught card 1",
        32'(readout_en), 32'h17F5);

    // R7: pops with an empty FIFO are ignored
    pop_any = 1; repeat (6) @(posedge clk); #1; pop_any = 0;
    @(negedge clk);
    chk(wrn_valid == 1'b0, "R7 empty pop ignored", 32'(wrn_valid), 0);
    @(posedge clk); #1;
    err_of[5] = 8'h20;
    settle();

    // R8: soft faults on all powered cards with the FIFO not drained
    pop_en = 0;
    for (int i = 0; i < N; i++) if (!m_off[i]) err_of[i] = 8'h40;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(q.size() == DEPTH, "R8 FIFO filled", q.size(), DEPTH);
    chk(req_valid == 1'b0, "R8 stalled with full FIFO", 32'(req_valid), 0);
    @(posedge clk); #1; pop_en = 1;
    settle();
    chk(card_off == 13'h0280, "R3 R10 off cards kept", 32'(card_off), 32'h0280);
    chk(q.size() == 0, "R7 FIFO drained", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule